// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits between operand read and the data-cache request of an integer pipeline. For each memory operation it forms the 64-bit byte address from two register operands, or from one register and a 13-bit signed immediate. It attaches an 8-bit address-space identifier and checks the address against two rules: the access must be aligned to its size, and the address must fall in the implemented virtual range. The implemented range is split. Only the lowest and highest 2^(VA_BITS-1) bytes of the 64-bit space are legal, and a hole lies between them.

The unit also prepares the data-bus side of the access for a big-endian 64-bit bus. It produces one enable per byte lane, with the lowest address on the most significant lane. For stores it shifts the store datum into those lanes. All results appear one clock after the request, together with a valid flag. An access that traps enables no lanes.

Top module: `lsag_top`

## Requirements
- R1: With `use_imm` low, `out_addr` equals `rs1 + rs2` modulo 2^64.
- R2: With `use_imm` high, `out_addr` equals `rs1` plus `imm13` sign-extended to 64 bits, modulo 2^64. `rs2` is ignored.
- R3: `out_asi` equals `alt_asi` when `use_alt_asi` is high. Otherwise it equals `dflt_asi`, sampled with the request.
- R4: The `size` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `trap_misalign` is raised when the address is not a multiple of that byte count.
- R5: `trap_range` is raised when address bits 63 down to VA_BITS-1 (default VA_BITS = 48) are not all equal. This means the address lies outside [0, 2^(VA_BITS-1)-1] and outside [2^64-2^(VA_BITS-1), 2^64-1].
- R6: When an access is both misaligned and out of range, only `trap_misalign` is raised.
- R7: Lane i is enabled on `byte_en[i]` and carries data bits 8i+7..8i. Address offset k (address bits 2:0) maps to lane 7-k. An untrapped access of N bytes at offset k enables exactly lanes 7-k down to 8-k-N.
- R8: For an untrapped store, the low N bytes of `wdata` are placed in the enabled lanes. The datum's most significant byte goes to the lowest address. All other lanes of `out_wdata` are zero, and for loads `out_wdata` is zero.
- R9: A trapped access drives `byte_en` and `out_wdata` to zero.
- R10: The outputs describe the request of the previous clock: `out_valid` is the registered `req_valid`. In a cycle with `out_valid` low, `byte_en` and both traps are zero, and `out_addr`, `out_asi` and `out_is_store` keep their last values.
- R11: While `rst_n` is low, `out_valid`, both traps, `byte_en`, `out_wdata` and `out_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A memory operation is presented this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| use_imm | input | 1 | 1 = second operand is the immediate |
| rs1 | input | 64 | First register operand |
| rs2 | input | 64 | Second register operand |
| imm13 | input | 13 | Signed immediate |
| size | input | 2 | Access size code (see R4) |
| use_alt_asi | input | 1 | Take the identifier from `alt_asi` |
| alt_asi | input | 8 | Explicit address-space identifier |
| dflt_asi | input | 8 | Identifier used for ordinary accesses |
| wdata | input | 64 | Store datum, right-justified |
| out_valid | output | 1 | Results below belong to a request |
| out_addr | output | 64 | Effective byte address |
| out_asi | output | 8 | Attached address-space identifier |
| out_is_store | output | 1 | Registered load/store flag |
| trap_misalign | output | 1 | Alignment violation |
| trap_range | output | 1 | Address in the unimplemented hole |
| byte_en | output | 8 | Lane enables, lane 7 = lowest address |
| out_wdata | output | 64 | Lane-steered store data |

## Verification
The adder is exercised in both operand forms. This includes negative and maximum positive immediates, which separate correct sign extension from zero extension, and a carry across the full 64 bits. Every legal offset is swept for each of the four sizes, with a datum made of distinct bytes. A mirrored lane order or a wrong byte order inside the datum therefore shows up in the enables and the data.

Four addresses probe the range check: one on each side of both hole edges. They separate a check on the wrong bit from a correct one. Addresses that are both misaligned and in the hole test the trap priority. Idle cycles after a request show that the payload is held and that nothing is left enabled.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned LANES  = 8;
  localparam int unsigned DATA_W = 8 * LANES;
  localparam int unsigned OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsag_addr.sv
module lsag_addr
  import lsag_pkg::*;
#(
  parameter int unsigned IMM_W = 13
) (
  input  logic [ADDR_W-1:0] rs1,
  input  logic [ADDR_W-1:0] rs2,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] opb;

  always_comb begin
    opb = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : rs2;
    ea  = rs1 + opb;
  end
endmodule

// File: rtl/lsag_check.sv
module lsag_check
  import lsag_pkg::*;
#(
  parameter int unsigned VA_BITS = 48
) (
  input  logic [ADDR_W-1:0] ea,
  input  acc_size_e         size,
  output logic              mis,
  output logic              rng
);
  localparam int unsigned TOP_W = ADDR_W - VA_BITS + 1;

  logic [OFS_W:0]   span;
  logic [OFS_W-1:0] low_mask;
  logic [TOP_W-1:0] top;
  logic             in_hole;

  always_comb begin
    span     = (OFS_W+1)'(1) << size;
    low_mask = OFS_W'(span - (OFS_W+1)'(1));
    top      = ea[ADDR_W-1:VA_BITS-1];
    in_hole  = !((&top) || !(|top));
    mis      = |(ea[OFS_W-1:0] & low_mask);
    rng      = in_hole && !mis;
  end
endmodule

// File: rtl/lsag_lane.sv
module lsag_lane
  import lsag_pkg::*;
(
  input  logic [OFS_W-1:0]  off,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] sdata
);
  logic [OFS_W:0]    nbytes;
  logic [OFS_W:0]    sh;
  logic [LANES:0]    ones;
  logic [DATA_W-1:0] dmask;

  always_comb begin
    nbytes = (OFS_W+1)'(1) << size;
    sh     = (OFS_W+1)'(LANES) - {1'b0, off} - nbytes;
    ones   = ((LANES+1)'(1) << nbytes) - (LANES+1)'(1);
    be     = ones[LANES-1:0] << sh;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign dmask[8*i +: 8] = {8{ones[i]}};
  end

  assign sdata = (wdata & dmask) << {sh, 3'b000};
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int unsigned VA_BITS = 48,
  parameter int unsigned IMM_W   = 13,
  parameter int unsigned ASI_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               is_store,
  input  logic               use_imm,
  input  logic [63:0]        rs1,
  input  logic [63:0]        rs2,
  input  logic [IMM_W-1:0]   imm13,
  input  logic [1:0]         size,
  input  logic               use_alt_asi,
  input  logic [ASI_W-1:0]   alt_asi,
  input  logic [ASI_W-1:0]   dflt_asi,
  input  logic [63:0]        wdata,
  output logic               out_valid,
  output logic [63:0]        out_addr,
  output logic [ASI_W-1:0]   out_asi,
  output logic               out_is_store,
  output logic               trap_misalign,
  output logic               trap_range,
  output logic [7:0]         byte_en,
  output logic [63:0]        out_wdata
);
  acc_size_e         sz;
  logic [ADDR_W-1:0] ea;
  logic              mis, rng;
  logic [LANES-1:0]  be_raw;
  logic [DATA_W-1:0] sd_raw;

  assign sz = acc_size_e'(size);

  lsag_addr #(.IMM_W(IMM_W)) u_addr (
    .rs1(rs1), .rs2(rs2), .imm(imm13), .use_imm(use_imm), .ea(ea)
  );

  lsag_check #(.VA_BITS(VA_BITS)) u_check (
    .ea(ea), .size(sz), .mis(mis), .rng(rng)
  );

  lsag_lane u_lane (
    .off(ea[OFS_W-1:0]), .size(sz), .wdata(wdata), .be(be_raw), .sdata(sd_raw)
  );

  // next state
  logic              ok_n;
  logic [LANES-1:0]  be_n;
  logic [DATA_W-1:0] wd_n;
  logic [ASI_W-1:0]  asi_n;

  always_comb begin
    ok_n  = req_valid && !mis && !rng;
    be_n  = ok_n ? be_raw : '0;
    wd_n  = (ok_n && is_store) ? sd_raw : '0;
    asi_n = use_alt_asi ? alt_asi : dflt_asi;
  end

  // registers
  acc_size_e size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      trap_misalign <= 1'b0;
      trap_range    <= 1'b0;
      byte_en       <= '0;
      out_wdata     <= '0;
      out_addr      <= '0;
      out_asi       <= '0;
      out_is_store  <= 1'b0;
      size_q        <= SZ_BYTE;
    end else begin
      out_valid     <= req_valid;
      trap_misalign <= req_valid && mis;
      trap_range    <= req_valid && rng;
      byte_en       <= be_n;
      if (req_valid) begin
        out_wdata    <= wd_n;
        out_addr     <= ea;
        out_asi      <= asi_n;
        out_is_store <= is_store;
        size_q       <= sz;
      end
    end
  end

  // assertions
  logic [OFS_W-1:0] chk_mask;
  assign chk_mask = OFS_W'(((OFS_W+1)'(1) << size_q) - (OFS_W+1)'(1));

  AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_misalign && trap_range)); // R6
  AST_TRAP_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_misalign || trap_range) |-> (byte_en == '0 && out_wdata == '0)); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (byte_en == '0 && !trap_misalign && !trap_range)); // R10
  AST_ALIGNED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap_misalign) |-> ((out_addr[OFS_W-1:0] & chk_mask) == '0)); // R4
  AST_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap_misalign && !trap_range) |->
      ((&out_addr[63:VA_BITS-1]) || !(|out_addr[63:VA_BITS-1]))); // R5
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap_misalign && !trap_range) |->
      ($countones(byte_en) == (1 << size_q))); // R7
endmodule

// File: tb/lsag_top_test.sv
`timescale 1ns/1ps
module lsag_top_test;
  localparam int VA = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, is_store, use_imm, use_alt_asi;
  logic [63:0] rs1, rs2, wdata;
  logic [12:0] imm13;
  logic [1:0]  size;
  logic [7:0]  alt_asi, dflt_asi;
  logic        out_valid, out_is_store, trap_misalign, trap_range;
  logic [63:0] out_addr, out_wdata;
  logic [7:0]  out_asi, byte_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lsag_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
    .use_imm(use_imm), .rs1(rs1), .rs2(rs2), .imm13(imm13), .size(size),
    .use_alt_asi(use_alt_asi), .alt_asi(alt_asi), .dflt_asi(dflt_asi),
    .wdata(wdata), .out_valid(out_valid), .out_addr(out_addr),
    .out_asi(out_asi), .out_is_store(out_is_store),
    .trap_misalign(trap_misalign), .trap_range(trap_range),
    .byte_en(byte_en), .out_wdata(out_wdata)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_be(logic [2:0] off, logic [1:0] sz);
    logic [7:0] r = '0;
    for (int i = 0; i < (1 << sz); i++) r[7 - (off + i)] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] ref_data(logic [2:0] off, logic [1:0] sz, logic [63:0] d);
    logic [63:0] r = '0;
    int n = 1 << sz;
    for (int i = 0; i < n; i++) r[8*(7-(off+i)) +: 8] = d[8*(n-1-i) +: 8];
    return r;
  endfunction

  // Drives one request, waits for its result and checks every output.
  task automatic issue(string req, logic st, logic imf, logic [63:0] a, logic [63:0] b,
                       logic [12:0] im, logic [1:0] sz, logic alt, logic [7:0] aasi,
                       logic [63:0] d);
    logic [63:0] ea, lim;
    logic        em, er;
    logic [7:0]  ebe;
    logic [63:0] ewd;
    @(negedge clk);
    req_valid = 1'b1; is_store = st; use_imm = imf; rs1 = a; rs2 = b; imm13 = im;
    size = sz; use_alt_asi = alt; alt_asi = aasi; wdata = d;
    ea  = a + (imf ? {{51{im[12]}}, im} : b);
    lim = 64'd1 << (VA - 1);
    em  = (ea % (64'd1 << sz)) != 0;
    er  = !em && !((ea < lim) || (ea >= (64'd0 - lim)));
    ebe = (em || er) ? 8'h00 : ref_be(ea[2:0], sz);
    ewd = (em || er || !st) ? 64'h0 : ref_data(ea[2:0], sz, d);
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(req, "valid", {63'd0, out_valid}, 64'd1);
    chk(req, "addr", out_addr, ea);
    chk(req, "asi", {56'd0, out_asi}, {56'd0, alt ? aasi : dflt_asi});
    chk(req, "store", {63'd0, out_is_store}, {63'd0, st});
    chk(req, "misalign", {63'd0, trap_misalign}, {63'd0, em});
    chk(req, "range", {63'd0, trap_range}, {63'd0, er});
    chk(req, "byte_en", {56'd0, byte_en}, {56'd0, ebe});
    chk(req, "wdata", out_wdata, ewd);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; is_store = 1'b0; use_imm = 1'b0;
    rs1 = '0; rs2 = '0; imm13 = '0; size = '0; use_alt_asi = 1'b0;
    alt_asi = '0; dflt_asi = 8'h80; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "valid", {63'd0, out_valid}, 64'd0);
    chk("R11", "traps", {62'd0, trap_misalign, trap_range}, 64'd0);
    chk("R11", "byte_en", {56'd0, byte_en}, 64'd0);
    chk("R11", "addr", out_addr, 64'd0);
    chk("R11", "wdata", out_wdata, 64'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reg_form; // R1
    issue("R1", 0, 0, 64'h0000_1000_0000_0000, 64'h0000_0000_0000_0238, 13'h0, 3, 0, 0, 0);
    issue("R1", 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 13'h0, 2, 0, 0, 0);
  endtask

  task automatic t_imm_form; // R2
    issue("R2", 0, 1, 64'h100, 64'hDEAD_0000_0000_0000, 13'h1FF8, 3, 0, 0, 0);
    issue("R2", 0, 1, 64'h1, 64'h55, 13'h0FFF, 3, 0, 0, 0);
    issue("R2", 0, 1, 64'h0, 64'h0, 13'h1000, 0, 0, 0, 0);
  endtask

  task automatic t_asi; // R3
    issue("R3", 0, 0, 64'h40, 64'h0, 13'h0, 3, 1, 8'h2C, 0);
    dflt_asi = 8'h88;
    issue("R3", 0, 0, 64'h40, 64'h0, 13'h0, 3, 0, 8'h2C, 0);
    dflt_asi = 8'h80;
  endtask

  task automatic t_lanes; // R7 R8 R4
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o += (1 << s))
        issue("R7", 1, 0, 64'h2000 + o, 64'h0, 13'h0, 2'(s), 0, 0, 64'h8877_6655_4433_2211);
    issue("R8", 0, 0, 64'h2004, 64'h0, 13'h0, 2, 0, 0, 64'h8877_6655_4433_2211);
  endtask

  task automatic t_misalign; // R4 R9
    issue("R4", 1, 0, 64'h3001, 64'h0, 13'h0, 1, 0, 0, 64'hFFFF);
    issue("R4", 1, 0, 64'h3006, 64'h0, 13'h0, 2, 0, 0, 64'hFFFF);
    issue("R4", 0, 0, 64'h3004, 64'h0, 13'h0, 3, 0, 0, 0);
    issue("R9", 1, 0, 64'h3007, 64'h0, 13'h0, 0, 0, 0, 64'hAB);
  endtask

  task automatic t_range; // R5 R9
    issue("R5", 1, 0, 64'h0000_7FFF_FFFF_FFF8, 64'h0, 13'h0, 3, 0, 0, 64'h1234);
    issue("R5", 1, 0, 64'h0000_8000_0000_0000, 64'h0, 13'h0, 3, 0, 0, 64'h1234);
    issue("R5", 0, 0, 64'hFFFF_8000_0000_0000, 64'h0, 13'h0, 3, 0, 0, 0);
    issue("R5", 0, 0, 64'hFFFF_7FFF_FFFF_FFF8, 64'h0, 13'h0, 3, 0, 0, 0);
  endtask

  task automatic t_priority; // R6
    issue("R6", 1, 0, 64'h0000_8000_0000_0002, 64'h0, 13'h0, 2, 0, 0, 64'h1);
    issue("R6", 0, 0, 64'h4000_0000_0000_0001, 64'h0, 13'h0, 1, 0, 0, 0);
  endtask

  task automatic t_idle; // R10
    issue("R10", 1, 0, 64'h5008, 64'h0, 13'h0, 3, 1, 8'h11, 64'h77);
    @(negedge clk);
    rs1 = 64'h9999; use_alt_asi = 1'b0; is_store = 1'b0;
    @(posedge clk); #1;
    chk("R10", "valid idle", {63'd0, out_valid}, 64'd0);
    chk("R10", "byte_en idle", {56'd0, byte_en}, 64'd0);
    chk("R10", "traps idle", {62'd0, trap_misalign, trap_range}, 64'd0);
    chk("R10", "addr held", out_addr, 64'h5008);
    chk("R10", "asi held", {56'd0, out_asi}, 64'h11);
    chk("R10", "store held", {63'd0, out_is_store}, 64'd1);
  endtask

  initial begin
    t_reset();
    t_reg_form();
    t_imm_form();
    t_asi();
    t_lanes();
    t_misalign();
    t_range();
    t_priority();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule